// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Label and SD Filtering

This block takes the two logic-level line states of an ARINC 429 receive pair and rebuilds complete 32-bit words from them. The states have already been converted from the differential signal. The line uses return-to-zero coding. In each bit period the line is active for the first half and idle (null) for the second half. The high line active means 1, the low line active means 0, and both idle means null. The block counts samples of its own clock to find each bit. It runs at 10 clocks per bit at high speed (100 kbit/s from a 1 MHz clock) and at 80 clocks per bit at low speed (12.5 kbit/s). A word ends after a long run of null.

Each complete word is then tested three ways. It must have odd parity. Its 8 label bits must pass a per-bit mask against a reference label. Its bits 9 and 10 may optionally have to match two expected values. A word that passes is shown on a 32-bit parallel bus, with a one-cycle update pulse. A word that fails parity raises a one-cycle parity error pulse. A word that is rejected or discarded leaves the bus and the update line alone. The configuration inputs are meant to be held steady while a word is on the line.

Top module: `arinc_rx_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `word_out` is cleared to zero and `word_valid` and `parity_err` are held low.
- R2: Line coding: `line_hi` active alone is a 1, `line_lo` active alone is a 0, and both low is null. A word is 32 bits sent LSB first. The n-th bit received appears on `word_out[n-1]`. Each accepted word gives exactly one `word_valid` pulse one cycle wide.
- R3: With `speed_lo` = 0 a bit lasts 10 clocks, and with `speed_lo` = 1 it lasts 80 clocks. Words at either rate are received correctly.
- R4: A label mask bit of 0 makes that label bit (`word_out[i]`, i = 0..7) a don't-care. An all-zero mask accepts every label.
- R5: A label mask bit `label_mask[i]` of 1 requires `word_out[i]` to equal `ref_label[i]`. Otherwise the word is rejected.
- R6: With `sd_check_en` = 1 a word is accepted only if bit 9 (`word_out[8]`) equals `sd9_want` and bit 10 (`word_out[9]`) equals `sd10_want`.
- R7: With `sd_check_en` = 0, bits 9 and 10 and the two expected values have no effect on acceptance.
- R8: A word must have an odd number of ones across all 32 bits, with bit 32 (`word_out[31]`) as the parity bit. A complete word with even parity gives one `parity_err` pulse one cycle wide, and no update. `parity_err` and `word_valid` are never high together.
- R9: A word that is rejected by a filter, fails parity or is discarded leaves `word_out` unchanged and gives no `word_valid` pulse.
- R10: A word ends only after at least 4 bit-times of continuous null. A word that does not hold exactly 32 bits is discarded. This covers a short word, and two words separated by less than 4 bit-times of null.
- R11: If both lines are active together for at least a quarter of a bit time, the current word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (1 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| line_hi | input | 1 | High line of the pair is active |
| line_lo | input | 1 | Low line of the pair is active |
| speed_lo | input | 1 | 0 selects 100 kbit/s, 1 selects 12.5 kbit/s |
| ref_label | input | 8 | Reference label, bit i compared with word bit i+1 |
| label_mask | input | 8 | Per-bit label compare enable |
| sd_check_en | input | 1 | Enables the bit 9 / bit 10 check |
| sd9_want | input | 1 | Required value of word bit 9 |
| sd10_want | input | 1 | Required value of word bit 10 |
| word_out | output | 32 | Last accepted word |
| word_valid | output | 1 | One-cycle pulse when a word is accepted |
| parity_err | output | 1 | One-cycle pulse when a complete word has even parity |

## Verification
All ones (with parity cleared) and all zeros (with parity set) show that each bit lands in its own output position, independently of the others. Alternating patterns with good parity show that no two bits are swapped and that the LSB-first order holds. The same pattern with its parity bit left even is used to separate a parity failure from a filter rejection. Labels with full, partial and empty masks, and words whose bits 9 and 10 do or do not match, show which bits the filters read. Short words, merged words and words with a both-lines fault show that framing errors are dropped without touching the bus. Low speed is run with two patterns.

// File: rtl/arinc_rx_pkg.sv
// Package: shared types and constants for the ARINC 429 word receiver.
// Assumes the word length is fixed by the line standard at 32 bits.
package arinc_rx_pkg;

    localparam int WORD_BITS  = 32;
    localparam int LABEL_BITS = 8;

    // Decoded state of the receive pair after synchronisation
    typedef enum logic [1:0] {
        LN_NULL  = 2'b00,
        LN_ONE   = 2'b01,
        LN_ZERO  = 2'b10,
        LN_CLASH = 2'b11
    } line_e;

endpackage

// File: rtl/arinc_line_sync.sv
// Module: arinc_line_sync
// Brings the two asynchronous line states into the clock domain through a
// chain of SYNC_STAGES flops each, then decodes them into one line state.
// Assumes both inputs are already logic-level.
module arinc_line_sync
    import arinc_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_hi,
    input  logic  line_lo,
    output line_e line_st
);

    logic [SYNC_STAGES-1:0] hi_q;
    logic [SYNC_STAGES-1:0] lo_q;

    // First stage of each synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q[0] <= 1'b0;
            lo_q[0] <= 1'b0;
        end else begin
            hi_q[0] <= line_hi;
            lo_q[0] <= line_lo;
        end
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            // Further synchroniser stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_q[s] <= 1'b0;
                    lo_q[s] <= 1'b0;
                end else begin
                    hi_q[s] <= hi_q[s-1];
                    lo_q[s] <= lo_q[s-1];
                end
            end
        end
    endgenerate

    // Map the synchronised pair onto a line state
    always_comb begin
        line_st = line_e'({lo_q[SYNC_STAGES-1], hi_q[SYNC_STAGES-1]});
    end

endmodule

// File: rtl/arinc_bit_timer.sv
// Module: arinc_bit_timer
// Measures how long the line state has been held, in samples. It emits one
// bit strobe when an active state has lasted a quarter bit, a clash strobe
// when both lines have been active that long, and one gap strobe when null
// has lasted four bit times. Assumes speed_lo only changes while idle.
module arinc_bit_timer
    import arinc_rx_pkg::*;
#(
    parameter int HS_SPB = 10,
    parameter int LS_SPB = 80
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  speed_lo,
    input  line_e line_st,
    output logic  bit_stb,
    output logic  bit_val,
    output logic  clash_stb,
    output logic  gap_stb
);

    localparam int CNT_MAX = 4 * LS_SPB + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HS_MIN = CW'(HS_SPB / 4);
    localparam logic [CW-1:0] LS_MIN = CW'(LS_SPB / 4);
    localparam logic [CW-1:0] HS_GAP = CW'(4 * HS_SPB);
    localparam logic [CW-1:0] LS_GAP = CW'(4 * LS_SPB);
    localparam logic [CW-1:0] SAT    = CW'(CNT_MAX);

    line_e          prev_st;
    logic [CW-1:0]  run_cnt;
    logic [CW-1:0]  next_run;
    logic [CW-1:0]  min_act;
    logic [CW-1:0]  gap_len;

    // Select thresholds for the current rate and form the next run length
    always_comb begin
        min_act = speed_lo ? LS_MIN : HS_MIN;
        gap_len = speed_lo ? LS_GAP : HS_GAP;
        if (line_st != prev_st) begin
            next_run = CW'(1);
        end else if (run_cnt != SAT) begin
            next_run = run_cnt + CW'(1);
        end else begin
            next_run = run_cnt;
        end
    end

    // Track the run length and raise the timing strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_st   <= LN_NULL;
            run_cnt   <= '0;
            bit_stb   <= 1'b0;
            bit_val   <= 1'b0;
            clash_stb <= 1'b0;
            gap_stb   <= 1'b0;
        end else begin
            prev_st   <= line_st;
            run_cnt   <= next_run;
            bit_stb   <= ((line_st == LN_ONE) || (line_st == LN_ZERO)) &&
                         (next_run == min_act);
            bit_val   <= (line_st == LN_ONE);
            clash_stb <= (line_st == LN_CLASH) && (next_run == min_act);
            gap_stb   <= (line_st == LN_NULL) && (next_run == gap_len);
        end
    end

endmodule

// File: rtl/arinc_word_asm.sv
// Module: arinc_word_asm
// Shifts received bits into a word, first bit ending in position 0. At a
// gap strobe it reports a word only if exactly WORD_BITS bits arrived and
// no clash was seen, then starts over. Assumes strobes never coincide.
module arinc_word_asm
    import arinc_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 clash_stb,
    input  logic                 gap_stb,
    output logic                 word_done,
    output logic [WORD_BITS-1:0] word_data
);

    localparam int BW = $clog2(WORD_BITS + 2);
    localparam logic [BW-1:0] FULL = BW'(WORD_BITS);
    localparam logic [BW-1:0] OVER = BW'(WORD_BITS + 1);

    logic [BW-1:0] bit_cnt;
    logic          bad;

    // Collect bits, note faults, and close the word at the end gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_data <= '0;
            bit_cnt   <= '0;
            bad       <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (gap_stb) begin
                word_done <= (bit_cnt == FULL) && !bad;
                bit_cnt   <= '0;
                bad       <= 1'b0;
            end else begin
                if (bit_stb) begin
                    word_data <= {bit_val, word_data[WORD_BITS-1:1]};
                    if (bit_cnt != OVER) begin
                        bit_cnt <= bit_cnt + BW'(1);
                    end
                end
                if (clash_stb) begin
                    bad <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arinc_word_filter.sv
// Module: arinc_word_filter
// Checks parity, label and bits 9/10 of a finished word. It updates the
// parallel output and pulses the update line for an accepted word, or
// pulses the parity error line. Assumes configuration is stable per word.
module arinc_word_filter
    import arinc_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_done,
    input  logic [WORD_BITS-1:0]  word_data,
    input  logic [LABEL_BITS-1:0] ref_label,
    input  logic [LABEL_BITS-1:0] label_mask,
    input  logic                  sd_check_en,
    input  logic                  sd9_want,
    input  logic                  sd10_want,
    output logic [WORD_BITS-1:0]  word_out,
    output logic                  word_valid,
    output logic                  parity_err
);

    logic label_ok;
    logic sd_ok;
    logic parity_ok;

    // Evaluate the three acceptance conditions
    always_comb begin
        label_ok  = ((word_data[LABEL_BITS-1:0] ^ ref_label) & label_mask) == '0;
        sd_ok     = !sd_check_en ||
                    ((word_data[8] == sd9_want) && (word_data[9] == sd10_want));
        parity_ok = ^word_data;
    end

    // Register the output word and the two result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            parity_err <= 1'b0;
            if (word_done) begin
                if (!parity_ok) begin
                    parity_err <= 1'b1;
                end else if (label_ok && sd_ok) begin
                    word_out   <= word_data;
                    word_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arinc_rx_filter.sv
// Module: arinc_rx_filter (top)
// Receives ARINC 429 words from two logic-level line states, frames them,
// and shows each word that passes the parity, label and bit 9/10 checks on
// a parallel bus with an update pulse. Assumes clk is the sample clock
// (1 MHz nominal) and configuration inputs change only between words.
module arinc_rx_filter
    import arinc_rx_pkg::*;
#(
    parameter int HS_SPB      = 10,
    parameter int LS_SPB      = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        speed_lo,
    input  logic [7:0]  ref_label,
    input  logic [7:0]  label_mask,
    input  logic        sd_check_en,
    input  logic        sd9_want,
    input  logic        sd10_want,
    output logic [31:0] word_out,
    output logic        word_valid,
    output logic        parity_err
);

    line_e                line_st;
    logic                 bit_stb;
    logic                 bit_val;
    logic                 clash_stb;
    logic                 gap_stb;
    logic                 word_done;
    logic [WORD_BITS-1:0] word_data;

    arinc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_hi (line_hi),
        .line_lo (line_lo),
        .line_st (line_st)
    );

    arinc_bit_timer #(.HS_SPB(HS_SPB), .LS_SPB(LS_SPB)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_lo  (speed_lo),
        .line_st   (line_st),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .clash_stb (clash_stb),
        .gap_stb   (gap_stb)
    );

    arinc_word_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .clash_stb (clash_stb),
        .gap_stb   (gap_stb),
        .word_done (word_done),
        .word_data (word_data)
    );

    arinc_word_filter u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_done   (word_done),
        .word_data   (word_data),
        .ref_label   (ref_label),
        .label_mask  (label_mask),
        .sd_check_en (sd_check_en),
        .sd9_want    (sd9_want),
        .sd10_want   (sd10_want),
        .word_out    (word_out),
        .word_valid  (word_valid),
        .parity_err  (parity_err)
    );

endmodule

// File: rtl/arinc_rx_filter_chk.sv
// Module: arinc_rx_filter_chk
// Checker bound to arinc_rx_filter: it watches the output pulses and the
// output word against the configuration inputs.
module arinc_rx_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] word_out,
    input logic        word_valid,
    input logic        parity_err,
    input logic [7:0]  ref_label,
    input logic [7:0]  label_mask,
    input logic        sd_check_en,
    input logic        sd9_want,
    input logic        sd10_want
);

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_label_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (((word_out[7:0] ^ ref_label) & label_mask) == 8'h00));

    assert_sd_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && sd_check_en) |-> ((word_out[8] == sd9_want) && (word_out[9] == sd10_want)));

    assert_odd_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (^word_out));

    assert_perr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |=> !parity_err);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && parity_err));

    assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

endmodule

bind arinc_rx_filter arinc_rx_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_out    (word_out),
    .word_valid  (word_valid),
    .parity_err  (parity_err),
    .ref_label   (ref_label),
    .label_mask  (label_mask),
    .sd_check_en (sd_check_en),
    .sd9_want    (sd9_want),
    .sd10_want   (sd10_want)
);

// File: tb/test_arinc_rx_filter.sv
// Bench for arinc_rx_filter: it walks a table of words and settings, then
// runs directed tests for reset, framing faults and clashes.
module test_arinc_rx_filter;

    localparam int HS = 10;
    localparam int LS = 80;
    localparam int WATCHDOG_CYCLES = 150000;

    typedef struct packed {
        logic [31:0] w;
        logic        spd;
        logic [7:0]  msk;
        logic [7:0]  lbl;
        logic        sde;
        logic        s9;
        logic        s10;
        logic        acc;
        logic        perr;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'hD5555555, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2},  // R2 R4
        '{32'h7FFFFFFF, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2},  // R2
        '{32'h80000000, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2},  // R2
        '{32'hD5555555, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 R9
        '{32'hD5555555, 1'b0, 8'hFF, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5},  // R5
        '{32'h2AAAAAAA, 1'b0, 8'h0F, 8'h0A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4},  // R4 partial mask
        '{32'h2AAAAAAA, 1'b0, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 R9
        '{32'h2AAAAAAA, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 match
        '{32'hD5555555, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 mismatch
        '{32'hD5555555, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7},  // R7
        '{32'h55555555, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8},  // R8
        '{32'h7FFFFFFF, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3},  // R3
        '{32'h2AAAAAAA, 1'b1, 8'hFF, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_hi = 1'b0;
    logic        line_lo = 1'b0;
    logic        speed_lo = 1'b0;
    logic [7:0]  ref_label = 8'h00;
    logic [7:0]  label_mask = 8'h00;
    logic        sd_check_en = 1'b0;
    logic        sd9_want = 1'b0;
    logic        sd10_want = 1'b0;
    logic [31:0] word_out;
    logic        word_valid;
    logic        parity_err;

    int n_checks = 0;
    int n_fails  = 0;
    int n_upd    = 0;
    int n_perr   = 0;
    logic [31:0] exp_word = 32'h0;

    always #2.5 clk = ~clk;

    arinc_rx_filter i_arinc_rx_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_hi     (line_hi),
        .line_lo     (line_lo),
        .speed_lo    (speed_lo),
        .ref_label   (ref_label),
        .label_mask  (label_mask),
        .sd_check_en (sd_check_en),
        .sd9_want    (sd9_want),
        .sd10_want   (sd10_want),
        .word_out    (word_out),
        .word_valid  (word_valid),
        .parity_err  (parity_err)
    );

    // Count output pulses
    always @(posedge clk) begin
        if (word_valid) n_upd++;
        if (parity_err) n_perr++;
    end

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Send nbits of w LSB first; bit clash_at drives both lines; then gap
    task automatic send_word(input logic [31:0] w, input int nbits,
                             input int clash_at, input int gap_bits);
        int half;
        half = (speed_lo ? LS : HS) / 2;
        for (int k = 0; k < nbits; k++) begin
            line_hi = (k == clash_at) ? 1'b1 : w[k];
            line_lo = (k == clash_at) ? 1'b1 : !w[k];
            repeat (half) @(negedge clk);
            line_hi = 1'b0;
            line_lo = 1'b0;
            repeat (half) @(negedge clk);
        end
        repeat (gap_bits * 2 * half) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(WATCHDOG_CYCLES * 5.0);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int u0;
        int p0;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", "word_out after reset", word_out, 32'h0);
        check("R1", "word_valid after reset", {31'h0, word_valid}, 32'h0);
        check("R1", "parity_err after reset", {31'h0, parity_err}, 32'h0);
        repeat (60) @(negedge clk);

        // Table walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].rq);
            speed_lo    = VECS[i].spd;
            label_mask  = VECS[i].msk;
            ref_label   = VECS[i].lbl;
            sd_check_en = VECS[i].sde;
            sd9_want    = VECS[i].s9;
            sd10_want   = VECS[i].s10;
            @(negedge clk);
            u0 = n_upd;
            p0 = n_perr;
            send_word(VECS[i].w, 32, -1, 6);
            if (VECS[i].acc) exp_word = VECS[i].w;
            check(rq, $sformatf("vector %0d update count", i), n_upd - u0, {31'h0, VECS[i].acc});
            check(rq, $sformatf("vector %0d parity count", i), n_perr - p0, {31'h0, VECS[i].perr});
            check(rq, $sformatf("vector %0d word_out", i), word_out, exp_word);
        end

        speed_lo = 1'b0; label_mask = 8'h00; sd_check_en = 1'b0;
        @(negedge clk);

        // R10: short word of 31 bits is discarded
        u0 = n_upd;
        send_word(32'h7FFFFFFF, 31, -1, 6);
        check("R10", "short word updates", n_upd - u0, 32'd0);
        check("R10", "short word keeps output", word_out, exp_word);

        // R10: two words with only 2 bit-times of null merge and are dropped
        u0 = n_upd;
        send_word(32'h80000000, 32, -1, 2);
        send_word(32'hD5555555, 32, -1, 6);
        check("R10", "merged words updates", n_upd - u0, 32'd0);
        check("R10", "merged words keep output", word_out, exp_word);

        // R10: a good word after the fault is received again
        u0 = n_upd;
        send_word(32'h80000000, 32, -1, 6);
        exp_word = 32'h80000000;
        check("R10", "recovery update", n_upd - u0, 32'd1);
        check("R10", "recovery word", word_out, exp_word);

        // R11: both lines active in one bit discards the word
        u0 = n_upd;
        p0 = n_perr;
        send_word(32'h7FFFFFFF, 32, 12, 6);
        check("R11", "clash updates", n_upd - u0, 32'd0);
        check("R11", "clash parity pulses", n_perr - p0, 32'd0);
        check("R11", "clash keeps output", word_out, exp_word);

        // R1: reset after activity clears the output
        do_reset();
        check("R1", "word_out after second reset", word_out, 32'h0);
        check("R1", "word_valid after second reset", {31'h0, word_valid}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule